// File: doc/BRIEF.md
# Regulator Output Reference Chain

This block turns a handful of programmed settings and a live output-current reading into the digital reference word that a regulator's control loop tracks. An operating-mode field picks one of three stored setpoints: nominal, raised margin or lowered margin. A signed user trim and a signed factory calibration are then added to it. A droop term proportional to positive output current is taken off next. The result is floored at zero and limited to a programmed ceiling. Last, it is multiplied by an unsigned loop-gain factor that matches the external feedback divider.

The computation runs in three register stages. Whenever the ceiling limits the value, a sticky alarm is raised. The alarm stays high until a clear strobe arrives in a cycle in which no new limit event is present. The block has no bus logic and no register storage; the surrounding logic holds the settings and drives them in as plain inputs.

Top module: `vout_ref_chain`

## Requirements
- R1: After reset, `vref` is 0 and `limit_alarm` is 0.
- R2: `op_mode` selects the base setpoint: 2'b00 selects `set_nom`, 2'b01 selects `set_hi`, 2'b10 selects `set_lo`, and 2'b11 falls back to `set_nom`.
- R3: `user_trim` and `fact_cal` are 16-bit two's-complement offsets, both added to the base setpoint in 20-bit signed arithmetic.
- R4: When `i_out` (12-bit two's complement) is greater than zero, floor(`droop_k` × `i_out` / 16) is subtracted. When `i_out` is zero or negative, droop changes nothing.
- R5: A running value below zero after droop becomes zero.
- R6: A running value strictly above `v_ceiling` is replaced by `v_ceiling`.
- R7: The limited value v is scaled as floor((v × `loop_gain` + 16384) / 32768), with `loop_gain` unsigned and carrying 15 fractional bits. Results above 65535 saturate to 65535.
- R8: `vref` reflects inputs held stable across three rising clock edges. A change at the inputs leaves `vref` untouched after two edges and shows after the third.
- R9: A limit event (R6) sets `limit_alarm`, which then stays set until `clear_faults` is high at a clock edge.
- R10: When `clear_faults` coincides with a limit event reaching the alarm stage, `limit_alarm` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 2 | Setpoint selector |
| set_nom | input | 16 | Nominal setpoint, unsigned |
| set_hi | input | 16 | Raised margin setpoint, unsigned |
| set_lo | input | 16 | Lowered margin setpoint, unsigned |
| user_trim | input | 16 | Signed user offset |
| fact_cal | input | 16 | Signed factory offset |
| droop_k | input | 8 | Unsigned droop coefficient, 4 fractional bits |
| i_out | input | 12 | Signed measured output current |
| v_ceiling | input | 16 | Maximum allowed value before scaling |
| loop_gain | input | 16 | Unsigned loop scale, 15 fractional bits |
| clear_faults | input | 1 | Alarm clear strobe |
| vref | output | 16 | Final reference word |
| limit_alarm | output | 1 | Sticky ceiling alarm |

## Verification
A corrupted sum or droop register shows at `vref` exactly three edges after the stimulus. In a swept configuration it is large enough to move the rounded, scaled word, unless the ceiling or the zero floor masks it. The sweep therefore pairs every offset and droop case with an open ceiling and a gain of one. A lost or spurious limit flag shows on `limit_alarm` at the first clear strobe after the pipeline has filled. A stuck alarm shows when a run of unlimited values is followed by a clear.

// File: rtl/vout_ref_chain.sv
module vout_ref_chain #(
  parameter int SP_W       = 16,
  parameter int ACC_W      = 20,
  parameter int DK_W       = 8,
  parameter int DK_FRAC    = 4,
  parameter int IO_W       = 12,
  parameter int GAIN_W     = 16,
  parameter int GAIN_FRAC  = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           op_mode,
  input  logic [SP_W-1:0]      set_nom,
  input  logic [SP_W-1:0]      set_hi,
  input  logic [SP_W-1:0]      set_lo,
  input  logic [SP_W-1:0]      user_trim,
  input  logic [SP_W-1:0]      fact_cal,
  input  logic [DK_W-1:0]      droop_k,
  input  logic [IO_W-1:0]      i_out,
  input  logic [SP_W-1:0]      v_ceiling,
  input  logic [GAIN_W-1:0]    loop_gain,
  input  logic                 clear_faults,
  output logic [SP_W-1:0]      vref,
  output logic                 limit_alarm
);
  localparam int EXT    = ACC_W - SP_W;
  localparam int PROD_W = DK_W + IO_W - 1;
  localparam int DR_W   = PROD_W - DK_FRAC;
  localparam int MUL_W  = SP_W + GAIN_W + 1;
  localparam int OUT_W  = MUL_W - GAIN_FRAC;
  localparam logic [MUL_W-1:0] HALF = MUL_W'(1) << (GAIN_FRAC - 1);

  // stage 1: select, offsets, droop magnitude
  logic [SP_W-1:0]          base;
  logic signed [ACC_W-1:0]  sum_c, s1_sum;
  logic [ACC_W-1:0]         s1_droop;
  logic [PROD_W-1:0]        dprod;
  logic                     i_pos;

  always_comb begin
    unique case (op_mode)
      2'b01:   base = set_hi;
      2'b10:   base = set_lo;
      default: base = set_nom;
    endcase
  end

  assign sum_c = $signed({{EXT{1'b0}}, base})
               + $signed({{EXT{user_trim[SP_W-1]}}, user_trim})
               + $signed({{EXT{fact_cal[SP_W-1]}}, fact_cal});
  assign i_pos = !i_out[IO_W-1] && (i_out != '0);
  assign dprod = i_pos ? PROD_W'(droop_k) * PROD_W'(i_out[IO_W-2:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sum   <= '0;
      s1_droop <= '0;
    end else begin
      s1_sum   <= sum_c;
      s1_droop <= ACC_W'(dprod[PROD_W-1:DK_FRAC]);
    end
  end

  // stage 2: subtract droop, floor, ceiling
  logic signed [ACC_W:0]    diff;
  logic [ACC_W:0]           floored;
  logic                     over;
  logic [SP_W-1:0]          s2_val;
  logic                     s2_clamp;

  assign diff    = $signed({s1_sum[ACC_W-1], s1_sum}) - $signed({1'b0, s1_droop});
  assign floored = diff[ACC_W] ? '0 : diff;
  assign over    = floored > (ACC_W+1)'(v_ceiling);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_val   <= '0;
      s2_clamp <= 1'b0;
    end else begin
      s2_val   <= over ? v_ceiling : floored[SP_W-1:0];
      s2_clamp <= over;
    end
  end

  // stage 3: scale with round half up and saturation, sticky alarm
  logic [MUL_W-1:0] scaled;
  logic [OUT_W-1:0] q;

  assign scaled = MUL_W'(s2_val) * MUL_W'(loop_gain) + HALF;
  assign q      = scaled[MUL_W-1:GAIN_FRAC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vref        <= '0;
      limit_alarm <= 1'b0;
    end else begin
      vref        <= (q > OUT_W'({SP_W{1'b1}})) ? {SP_W{1'b1}} : q[SP_W-1:0];
      limit_alarm <= s2_clamp | (limit_alarm & ~clear_faults);
    end
  end

  AST_DROOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (i_out[IO_W-1] || i_out == '0) |=> (s1_droop == '0)); // R4

  AST_CEILING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (s2_val <= $past(v_ceiling))); // R6

  AST_ZERO_SCALES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_val == '0) |=> (vref == '0)); // R7

  AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    s2_clamp |=> limit_alarm); // R10

  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_alarm && !clear_faults) |=> limit_alarm); // R9

  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_faults && !s2_clamp) |=> !limit_alarm); // R9
endmodule

// File: tb/tb_vout_ref_chain.sv
`timescale 1ns/1ps
module tb_vout_ref_chain;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] op_mode = '0;
  logic [15:0] set_nom = 16'd30000, set_hi = 16'd33000, set_lo = 16'd1000;
  logic [15:0] user_trim = '0, fact_cal = '0, v_ceiling = 16'hFFFF, loop_gain = 16'd32768;
  logic [7:0]  droop_k = '0;
  logic [11:0] i_out = '0;
  logic clear_faults = 1'b0;
  logic [15:0] vref;
  logic limit_alarm;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vout_ref_chain dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .set_nom(set_nom), .set_hi(set_hi),
    .set_lo(set_lo), .user_trim(user_trim), .fact_cal(fact_cal), .droop_k(droop_k),
    .i_out(i_out), .v_ceiling(v_ceiling), .loop_gain(loop_gain),
    .clear_faults(clear_faults), .vref(vref), .limit_alarm(limit_alarm)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int m, input int tr, input int ca, input int k,
                                input int io, input int vc, input int g,
                                output longint v, output bit c);
    longint s, p;
    s = (m == 1) ? 33000 : (m == 2) ? 1000 : 30000;
    s = s + tr + ca;                              // R2 R3
    if (io > 0) s = s - ((k * io) / 16);          // R4
    if (s < 0) s = 0;                             // R5
    c = (s > vc);                                 // R6
    if (c) s = vc;
    p = (s * g + 16384) / 32768;                  // R7
    v = (p > 65535) ? 65535 : p;
  endfunction

  task automatic apply(input int m, input int tr, input int ca, input int k,
                       input int io, input int vc, input int g);
    op_mode = 2'(m); user_trim = 16'(tr); fact_cal = 16'(ca);
    droop_k = 8'(k); i_out = 12'(io); v_ceiling = 16'(vc); loop_gain = 16'(g);
  endtask

  int trims[6] = '{-32768, -1000, 0, 1, 2000, 32767};
  int cals[3]  = '{-20000, 0, 500};
  int ious[5]  = '{-100, 0, 1, 700, 2047};
  int ks[3]    = '{0, 3, 255};
  int vcs[3]   = '{0, 31000, 65535};
  int gs[4]    = '{0, 16385, 32768, 65535};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    longint ev; bit ec;
    repeat (3) @(negedge clk);
    chk("R1 vref at reset", vref, 0);
    chk("R1 alarm at reset", limit_alarm, 0);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++)
    for (int a = 0; a < 6; a++)
    for (int b = 0; b < 3; b++)
    for (int d = 0; d < 5; d++)
    for (int e = 0; e < 3; e++)
    for (int f = 0; f < 3; f++)
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      apply(m, trims[a], cals[b], ks[e], ious[d], vcs[f], gs[h]);
      model(m, trims[a], cals[b], ks[e], ious[d], vcs[f], gs[h], ev, ec);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R2 R3 R4 R5 R6 R7 chain vref", vref, ev);
      clear_faults = 1'b1;
      @(negedge clk);
      clear_faults = 1'b0;
      chk("R9 alarm after clear", limit_alarm, ec);
    end

    // R8 latency: nominal then raised margin, unity gain
    @(negedge clk);
    apply(0, 0, 0, 0, 0, 65535, 32768);
    repeat (4) @(negedge clk);
    chk("R8 settled old", vref, 30000);
    op_mode = 2'b01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 unchanged after two edges", vref, 30000);
    @(negedge clk);
    chk("R8 changed after three edges", vref, 33000);

    // R9 sticky alarm, R10 clear with simultaneous event
    apply(0, 0, 0, 0, 0, 100, 32768);
    repeat (4) @(negedge clk);
    chk("R6 clamped value", vref, 100);
    clear_faults = 1'b1;
    @(negedge clk);
    chk("R10 clear during limit", limit_alarm, 1);
    clear_faults = 1'b0;
    v_ceiling = 16'hFFFF;
    repeat (6) @(negedge clk);
    chk("R9 alarm sticky", limit_alarm, 1);
    chk("R9 unclamped value", vref, 30000);
    clear_faults = 1'b1;
    @(negedge clk);
    clear_faults = 1'b0;
    chk("R9 alarm cleared", limit_alarm, 0);

    // R4 negative current leaves value untouched
    apply(2, 0, 0, 255, -2048, 65535, 32768);
    repeat (4) @(negedge clk);
    chk("R4 negative current no droop", vref, 1000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule